// File: doc/BRIEF.md
# AV operating mode and routing controller

This block sits between the control registers of an audio/video switching device and its analog switch fabric. It takes the state of the power-down pin and four control bits (auto-startup enable, standby, bias mute, DAC power-down). From them it picks one of eight operating modes and drives the source-select codes for the TV, VCR and mono audio outputs. It also drives a video output enable, a video loop-through flag, the DAC run state and a one-cycle interrupt pulse.

In auto-startup mode everything except video detection is idle. A video-present indication on the TV or VCR detector moves the block into standby loop-through and raises the interrupt. In standby, audio routing is fixed to loop-through whatever the switch registers hold. The register inputs are never modified, so leaving standby restores the programmed routing at once. Source selects are combinational from the mode and the switch registers. The interrupt and the wake flag are registered on a synchronous active-high reset.

Top module: `avmode_ctrl`

## Requirements
- R1: With `pwr_on` low the mode is 0 (full power-down) regardless of every other input. All three audio selects are mute (code 0), and `vid_en`, `vid_loop` and `dac_on` are low. A low pin also clears any earlier wake-up.
- R2: With `pwr_on` high, `reg_auto` high and no wake-up since auto was last armed, the mode is 1 (auto-startup). All audio selects are mute, `vid_en` is low and `vid_loop` is high. This holds right after reset.
- R3: In mode 1, any bit of `vid_det` sampled high at a clock edge makes `irq` high for exactly the following cycle. From that cycle on, the mode is standby: 2 if `reg_mute` is high, else 3. `irq` does not fire again while video stays present, and it never fires outside mode 1.
- R4: Clearing `reg_auto` leaves auto-startup and the mode follows the other bits in the same cycle. Setting it again re-arms auto-startup (mode 1).
- R5: With `pwr_on` high and `reg_auto` low:
  - `reg_stby` high gives mode 2 when `reg_mute` is high and mode 3 when it is low, ignoring `reg_dapd`.
  - `reg_stby` low and `reg_mute` high gives mode 4 when `reg_dapd` is high and mode 5 when it is low.
  - `reg_stby` and `reg_mute` both low give mode 6 when `reg_dapd` is high and mode 7 when it is low.
- R6: In modes 2 and 3, `tv_src` and `mono_src` are VCR input (code 3) and `vcr_src` is TV input (code 4), whatever the switch registers hold. On leaving standby the selects again follow the unchanged register inputs.
- R7: In modes 4 to 7, `tv_sel` 00 gives DAC (code 1) and 01 gives VCR input (code 3). Codes 10 and 11 (reserved) give mute (code 0).
- R8: In modes 4 to 7, `vcr_sel` 00 gives DAC (1), 01 gives TV input (4), 10 gives mute (0) and 11 gives the main-volume output (code 5).
- R9: In modes 4 to 7, `mono_sel` 000, 001 and 010 give DAC bypassing the volume (1), 100 gives DAC through the volume (2) and 101 gives VCR input (3). Codes 110, 011 and 111 give mute (0).
- R10: `vid_en` is high exactly in modes 2 to 7. `vid_loop` (video switch registers overridden by fixed loop-through) is high exactly in modes 1 to 3.
- R11: `dac_on` is high exactly in modes 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | Power-down pin level, high = powered |
| reg_auto | input | 1 | Auto-startup enable bit |
| reg_stby | input | 1 | Standby bit |
| reg_mute | input | 1 | Audio bias mute bit |
| reg_dapd | input | 1 | DAC power-down / analog input bit |
| tv_sel | input | 2 | TV audio output switch register |
| vcr_sel | input | 2 | VCR audio output switch register |
| mono_sel | input | 3 | Mono output switch register |
| vid_det | input | NDET | Video-present indications (bit 0 TV, bit 1 VCR) |
| mode_o | output | 3 | Operating mode number 0..7 |
| tv_src | output | 3 | TV audio source code |
| vcr_src | output | 3 | VCR audio source code |
| mono_src | output | 3 | Mono audio source code |
| vid_en | output | 1 | Video outputs active |
| vid_loop | output | 1 | Video routing forced to loop-through |
| dac_on | output | 1 | DAC running |
| irq | output | 1 | One-cycle wake-up interrupt |

## Verification
The hardest state to reach is auto-enabled standby. It exists only as an internal wake flag that reset, a low pin or a cleared auto bit all wipe. So the bench first arms auto-startup with video absent and then raises one detector bit. It then holds that bit, flips the mute bit, clears and re-sets the auto bit while video is still present, and pulls the pin low, checking the interrupt and mode on the cycles around each step. The static decode is covered by an exhaustive sweep of all 4096 combinations of pin, control bits and switch registers with detection held low.

// File: rtl/avmode_pkg.sv
package avmode_pkg;

    localparam int MODE_W = 3;
    localparam int TSEL_W = 2;
    localparam int MSEL_W = 3;
    localparam int SRC_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        M_OFF       = 3'd0,
        M_AUTO      = 3'd1,
        M_STBY_MUTE = 3'd2,
        M_STBY      = 3'd3,
        M_MUTE_APD  = 3'd4,
        M_MUTE_DAC  = 3'd5,
        M_RUN_APD   = 3'd6,
        M_RUN_DAC   = 3'd7
    } opmode_e;

    typedef enum logic [SRC_W-1:0] {
        S_MUTE    = 3'd0,
        S_DAC     = 3'd1,
        S_DAC_VOL = 3'd2,
        S_VCR_IN  = 3'd3,
        S_TV_IN   = 3'd4,
        S_VOL_OUT = 3'd5
    } src_e;

    typedef struct packed {
        logic pin_on;
        logic auto_en;
        logic stby;
        logic mute;
        logic dapd;
    } ctl_t;

    typedef struct packed {
        src_e tv;
        src_e vcr;
        src_e mono;
    } route_t;

    function automatic logic is_standby(opmode_e m);
        return (m == M_STBY_MUTE) || (m == M_STBY);
    endfunction

    function automatic logic is_idle(opmode_e m);
        return (m == M_OFF) || (m == M_AUTO);
    endfunction

    function automatic logic dac_running(opmode_e m);
        return (m == M_MUTE_DAC) || (m == M_RUN_DAC);
    endfunction

endpackage

// File: rtl/avmode_decode.sv
module avmode_decode
    import avmode_pkg::*;
(
    input  ctl_t    ctl,
    input  logic    woken,
    output opmode_e mode
);
    always_comb begin
        if (!ctl.pin_on) begin
            mode = M_OFF;
        end else if (ctl.auto_en) begin
            if (woken) mode = ctl.mute ? M_STBY_MUTE : M_STBY;
            else       mode = M_AUTO;
        end else if (ctl.stby) begin
            mode = ctl.mute ? M_STBY_MUTE : M_STBY;
        end else if (ctl.mute) begin
            mode = ctl.dapd ? M_MUTE_APD : M_MUTE_DAC;
        end else begin
            mode = ctl.dapd ? M_RUN_APD : M_RUN_DAC;
        end
    end
endmodule

// File: rtl/avmode_wake.sv
module avmode_wake #(
    parameter int NDET = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            armed,
    input  logic [NDET-1:0] det,
    output logic            woken,
    output logic            irq
);
    logic any_det;
    assign any_det = |det;

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            woken <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= any_det && !woken;
            if (any_det) woken <= 1'b1;
        end
    end
endmodule

// File: rtl/avmode_route.sv
module avmode_route
    import avmode_pkg::*;
(
    input  opmode_e           mode,
    input  logic [TSEL_W-1:0] tv_sel,
    input  logic [TSEL_W-1:0] vcr_sel,
    input  logic [MSEL_W-1:0] mono_sel,
    output route_t            rt
);
    route_t from_regs;

    always_comb begin
        case (tv_sel)
            2'b00:   from_regs.tv = S_DAC;
            2'b01:   from_regs.tv = S_VCR_IN;
            default: from_regs.tv = S_MUTE;
        endcase
        case (vcr_sel)
            2'b00:   from_regs.vcr = S_DAC;
            2'b01:   from_regs.vcr = S_TV_IN;
            2'b11:   from_regs.vcr = S_VOL_OUT;
            default: from_regs.vcr = S_MUTE;
        endcase
        case (mono_sel)
            3'b000, 3'b001, 3'b010: from_regs.mono = S_DAC;
            3'b100:                 from_regs.mono = S_DAC_VOL;
            3'b101:                 from_regs.mono = S_VCR_IN;
            default:                from_regs.mono = S_MUTE;
        endcase
    end

    always_comb begin
        if (is_idle(mode)) begin
            rt = '{tv: S_MUTE, vcr: S_MUTE, mono: S_MUTE};
        end else if (is_standby(mode)) begin
            rt = '{tv: S_VCR_IN, vcr: S_TV_IN, mono: S_VCR_IN};
        end else begin
            rt = from_regs;
        end
    end
endmodule

// File: rtl/avmode_ctrl.sv
module avmode_ctrl
    import avmode_pkg::*;
#(
    parameter int NDET = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_on,
    input  logic              reg_auto,
    input  logic              reg_stby,
    input  logic              reg_mute,
    input  logic              reg_dapd,
    input  logic [TSEL_W-1:0] tv_sel,
    input  logic [TSEL_W-1:0] vcr_sel,
    input  logic [MSEL_W-1:0] mono_sel,
    input  logic [NDET-1:0]   vid_det,
    output logic [MODE_W-1:0] mode_o,
    output logic [SRC_W-1:0]  tv_src,
    output logic [SRC_W-1:0]  vcr_src,
    output logic [SRC_W-1:0]  mono_src,
    output logic              vid_en,
    output logic              vid_loop,
    output logic              dac_on,
    output logic              irq
);
    ctl_t    ctl;
    opmode_e mode;
    route_t  rt;
    logic    woken;

    assign ctl = '{pin_on: pwr_on, auto_en: reg_auto, stby: reg_stby,
                   mute: reg_mute, dapd: reg_dapd};

    avmode_wake #(.NDET(NDET)) u_wake (
        .clk   (clk),
        .rst   (rst),
        .armed (pwr_on && reg_auto),
        .det   (vid_det),
        .woken (woken),
        .irq   (irq)
    );

    avmode_decode u_dec (
        .ctl   (ctl),
        .woken (woken),
        .mode  (mode)
    );

    avmode_route u_route (
        .mode     (mode),
        .tv_sel   (tv_sel),
        .vcr_sel  (vcr_sel),
        .mono_sel (mono_sel),
        .rt       (rt)
    );

    assign mode_o   = mode;
    assign tv_src   = rt.tv;
    assign vcr_src  = rt.vcr;
    assign mono_src = rt.mono;
    assign vid_en   = !is_idle(mode);
    assign vid_loop = (mode == M_AUTO) || is_standby(mode);
    assign dac_on   = dac_running(mode);
endmodule

// File: rtl/avmode_ctrl_chk.sv
module avmode_ctrl_chk
    import avmode_pkg::*;
#(
    parameter int NDET = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_on,
    input logic              reg_auto,
    input logic              reg_stby,
    input logic              reg_mute,
    input logic              reg_dapd,
    input logic [TSEL_W-1:0] tv_sel,
    input logic [TSEL_W-1:0] vcr_sel,
    input logic [MSEL_W-1:0] mono_sel,
    input logic [NDET-1:0]   vid_det,
    input logic [MODE_W-1:0] mode_o,
    input logic [SRC_W-1:0]  tv_src,
    input logic [SRC_W-1:0]  vcr_src,
    input logic [SRC_W-1:0]  mono_src,
    input logic              vid_en,
    input logic              vid_loop,
    input logic              dac_on,
    input logic              irq
);
    p_pin_off_r1: assert property (@(posedge clk) disable iff (rst)
        !pwr_on |-> (mode_o == M_OFF && tv_src == S_MUTE && vcr_src == S_MUTE
                     && mono_src == S_MUTE && !vid_en && !dac_on));

    p_auto_modes_r2: assert property (@(posedge clk) disable iff (rst)
        (pwr_on && reg_auto) |-> (mode_o == M_AUTO || mode_o == M_STBY_MUTE || mode_o == M_STBY));

    p_irq_single_r3: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    p_irq_cause_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(mode_o) == M_AUTO && $past(|vid_det) && mode_o != M_AUTO));

    p_run_decode_r5: assert property (@(posedge clk) disable iff (rst)
        (pwr_on && !reg_auto && !reg_stby && !reg_mute && !reg_dapd) |-> mode_o == M_RUN_DAC);

    p_stby_route_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_STBY || mode_o == M_STBY_MUTE)
            |-> (tv_src == S_VCR_IN && vcr_src == S_TV_IN && mono_src == S_VCR_IN));

    p_tv_reserved_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_o >= 3'd4 && tv_sel[1]) |-> tv_src == S_MUTE);

    p_vcr_vol_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_o >= 3'd4 && vcr_sel == 2'b11) |-> vcr_src == S_VOL_OUT);

    p_mono_vcr_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_o >= 3'd4 && mono_sel == 3'b101) |-> mono_src == S_VCR_IN);

    p_vid_flags_r10: assert property (@(posedge clk) disable iff (rst)
        vid_loop |-> (mode_o >= 3'd1 && mode_o <= 3'd3));

    p_dac_r11: assert property (@(posedge clk) disable iff (rst)
        dac_on |-> (mode_o == M_MUTE_DAC || mode_o == M_RUN_DAC));
endmodule

bind avmode_ctrl avmode_ctrl_chk #(.NDET(NDET)) u_chk (.*);

// File: tb/avmode_ctrl_test.sv
module avmode_ctrl_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       pwr_on, reg_auto, reg_stby, reg_mute, reg_dapd;
    logic [1:0] tv_sel, vcr_sel;
    logic [2:0] mono_sel;
    logic [1:0] vid_det;
    logic [2:0] mode_o, tv_src, vcr_src, mono_src;
    logic       vid_en, vid_loop, dac_on, irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    avmode_ctrl #(.NDET(2)) uut (
        .clk(clk), .rst(rst), .pwr_on(pwr_on), .reg_auto(reg_auto),
        .reg_stby(reg_stby), .reg_mute(reg_mute), .reg_dapd(reg_dapd),
        .tv_sel(tv_sel), .vcr_sel(vcr_sel), .mono_sel(mono_sel),
        .vid_det(vid_det), .mode_o(mode_o), .tv_src(tv_src),
        .vcr_src(vcr_src), .mono_src(mono_src), .vid_en(vid_en),
        .vid_loop(vid_loop), .dac_on(dac_on), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_mode(bit p, bit a, bit s, bit m, bit d);
        if (!p) return 0;
        if (a)  return 1;
        if (s)  return 2 + int'(!m);
        return 4 + 2 * int'(!m) + int'(!d);
    endfunction

    function automatic int exp_tv(int md, int sel);
        if (md < 2) return 0;
        if (md < 4) return 3;
        return (sel == 0) ? 1 : (sel == 1) ? 3 : 0;
    endfunction

    function automatic int exp_vcr(int md, int sel);
        if (md < 2) return 0;
        if (md < 4) return 4;
        return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 3) ? 5 : 0;
    endfunction

    function automatic int exp_mono(int md, int sel);
        if (md < 2) return 0;
        if (md < 4) return 3;
        if (sel <= 2) return 1;
        return (sel == 4) ? 2 : (sel == 5) ? 3 : 0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pwr_on = 1'b1; reg_auto = 1'b1; reg_stby = 1'b1;
        reg_mute = 1'b1; reg_dapd = 1'b0; tv_sel = 2'b01; vcr_sel = 2'b00;
        mono_sel = 3'b101; vid_det = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk("R2 reset mode", int'(mode_o), 1);
        chk("R2 reset irq", int'(irq), 0);
        chk("R2 reset vid_en", int'(vid_en), 0);
        chk("R2 reset tv_src", int'(tv_src), 0);

        // Exhaustive static sweep (R1 R5 R6 R7 R8 R9 R10 R11), detection low
        for (int v = 0; v < 4096; v++) begin
            @(negedge clk);
            {pwr_on, reg_auto, reg_stby, reg_mute, reg_dapd} = v[11:7];
            tv_sel = v[6:5]; vcr_sel = v[4:3]; mono_sel = v[2:0];
            #5;
            begin
                int md;
                md = exp_mode(v[11], v[10], v[9], v[8], v[7]);
                chk("R1/R2/R5 mode", int'(mode_o), md);
                chk("R6/R7 tv_src", int'(tv_src), exp_tv(md, int'(v[6:5])));
                chk("R6/R8 vcr_src", int'(vcr_src), exp_vcr(md, int'(v[4:3])));
                chk("R6/R9 mono_src", int'(mono_src), exp_mono(md, int'(v[2:0])));
                chk("R10 vid_en", int'(vid_en), int'(md >= 2));
                chk("R10 vid_loop", int'(vid_loop), int'(md >= 1 && md <= 3));
                chk("R11 dac_on", int'(dac_on), int'(md == 5 || md == 7));
                chk("R3 no irq without detect", int'(irq), 0);
            end
        end

        // R6 register values survive standby
        @(negedge clk);
        pwr_on = 1; reg_auto = 0; reg_stby = 1; reg_mute = 0; reg_dapd = 0;
        tv_sel = 2'b00; vcr_sel = 2'b11; mono_sel = 3'b100;
        #5;
        chk("R6 stby tv", int'(tv_src), 3);
        chk("R6 stby vcr", int'(vcr_src), 4);
        @(negedge clk);
        reg_stby = 0;
        #5;
        chk("R6 exit tv", int'(tv_src), 1);
        chk("R6 exit vcr", int'(vcr_src), 5);
        chk("R6 exit mono", int'(mono_src), 2);

        // R3 detection never fires irq when not armed
        @(negedge clk); vid_det = 2'b11;
        @(negedge clk); chk("R3 no irq unarmed", int'(irq), 0);
        @(negedge clk); vid_det = 2'b00;

        // Auto-startup sequence
        @(negedge clk);
        reg_auto = 1; reg_stby = 1; reg_mute = 1;
        @(negedge clk);
        chk("R2 auto wait mode", int'(mode_o), 1);
        chk("R2 auto wait vid_loop", int'(vid_loop), 1);
        vid_det = 2'b01;
        #5;
        chk("R3 mode before edge", int'(mode_o), 1);
        @(negedge clk);
        chk("R3 irq pulse", int'(irq), 1);
        chk("R3 woke mode mute", int'(mode_o), 2);
        chk("R3 woke tv route", int'(tv_src), 3);
        @(negedge clk);
        chk("R3 irq single", int'(irq), 0);
        reg_mute = 0;
        #5;
        chk("R3 woke mode unmute", int'(mode_o), 3);
        @(negedge clk);
        chk("R3 no repeat", int'(irq), 0);
        reg_auto = 0; reg_stby = 0; reg_dapd = 0;
        #5;
        chk("R4 leave auto", int'(mode_o), 7);
        @(negedge clk);
        reg_auto = 1;
        #5;
        chk("R4 rearm mode", int'(mode_o), 1);
        @(negedge clk);
        chk("R4 rearm irq", int'(irq), 1);
        chk("R4 rearm woke", int'(mode_o), 3);
        @(negedge clk);
        vid_det = 2'b00; pwr_on = 0;
        #5;
        chk("R1 pin low", int'(mode_o), 0);
        @(negedge clk);
        pwr_on = 1;
        #5;
        chk("R1 pin clears wake", int'(mode_o), 1);
        @(negedge clk);
        vid_det = 2'b10;
        @(negedge clk);
        chk("R3 vcr detect irq", int'(irq), 1);
        chk("R3 vcr detect mode", int'(mode_o), 3);
        @(negedge clk);
        chk("R3 vcr irq single", int'(irq), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule